// File: doc/BRIEF.md
# Wide-Burst SPI Master

This block is a register-driven SPI master that moves up to 128 bits in one burst. Software loads four 32-bit data words, then writes a control word that holds the burst length in bits, the SCLK divider, a select-mode flag and a start bit. The shift engine sends the low N bits of the concatenated words, most significant bit first, in SPI mode 0. At the same time it collects N bits from MISO. When the burst ends, the received bits replace the data words, right-justified.

The chip-select pins have two modes. In automatic mode, a selected line is low only while a burst is running. In manual mode, the pins follow the select register directly. Software can then hold a device selected across many bursts and build one long device transaction, such as a command, an address and a page of data, out of pieces of at most 16 bytes.

Register map: data words sit at addresses 0 to NUM_WORDS-1, where address 0 holds the least significant word. The control word sits at address NUM_WORDS and the select register at NUM_WORDS+1. Reads are combinational.

Top module: `spi_wide_master`

## Requirements
- R1: After reset every `ss_n` pin is high, `sclk` is low, and the control word reads as zero with the busy bit 8 clear.
- R2: A burst of N bits drives MOSI with bits N-1 down to 0 of the concatenated words, most significant bit first. The top word (address 3) is the most significant, so a 128-bit burst sends word 3 first and word 0 last.
- R3: After a burst of N bits, the bit received first sits at position N-1 and the bit received last at position 0 of the concatenated words. Every bit above N-1 reads zero. After a 16-bit burst, a status byte returned in the last 8 clocks is in bits 7:0 of word 0.
- R4: The control word holds the length in bits 7:0. A start with length 0 is ignored: busy stays clear and no SCLK edge occurs. A length above 128 runs a 128-bit burst.
- R5: Control bit 8 starts a burst when written as 1. It reads 1 from the clock after that write until exactly one system clock after the last falling SCLK edge.
- R6: Any control write while busy is ignored. The length readback and the number of SCLK cycles of the running burst do not change.
- R7: With automatic select (control bit 9 = 1), the pin `ss_n[i]` is low exactly while busy and select bit i is 1. Otherwise it is high.
- R8: With automatic select clear, `ss_n` equals the inverse of the select register at all times, including the gaps between bursts.
- R9: SCLK idles low. MOSI changes only while SCLK is low, and the slave samples it on rising SCLK edges.
- R10: With divider value D in control bits 23:16, the first rising SCLK edge comes D+1 system clocks after the start write. Every later SCLK half period lasts D+1 system clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | $clog2(NUM_WORDS+2) | Register address for reads and writes |
| reg_wdata | input | WORD_W | Write data |
| reg_rdata | output | WORD_W | Combinational read data for `reg_addr` |
| sclk | output | 1 | SPI serial clock, mode 0 |
| mosi | output | 1 | Serial data to the slave |
| miso | input | 1 | Serial data from the slave |
| ss_n | output | NUM_SS | Active-low chip selects, one per slave |

## Verification
The bench builds the block with its default parameters: four 32-bit words, four selects and an 8-bit divider. This keeps the full 128-bit burst within reach, and it lets the length field hold values above 128 so the clamp can be exercised. Divider values 0, 1 and 3 cover the fastest SCLK and two slower ones while keeping bursts short. A slave model on select 0 returns known patterns and records MOSI for the scoreboard. The control and select registers are toggled between automatic and manual modes, and a start is written in the middle of a burst.

// File: rtl/spi_wide_pkg.sv
package spi_wide_pkg;

    // Control word field positions
    localparam int CTRL_LEN_LSB  = 0;
    localparam int LEN_FIELD_W   = 8;
    localparam int CTRL_GO_BIT   = 8;
    localparam int CTRL_AUTO_BIT = 9;
    localparam int CTRL_DIV_LSB  = 16;

    typedef enum logic [1:0] {
        ENG_IDLE   = 2'd0,
        ENG_SHIFT  = 2'd1,
        ENG_FINISH = 2'd2
    } eng_state_e;

endpackage

// File: rtl/spi_sclk_div.sv
module spi_sclk_div #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] half_div,
    output logic             tick
);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } div_t;

    div_t s_d, s_q;

    always_comb begin
        s_d  = s_q;
        tick = run && (s_q.cnt == half_div);
        if (!run || tick) begin
            s_d.cnt = '0;
        end else begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core
    import spi_wide_pkg::*;
#(
    parameter int TOTAL = 128,
    parameter int LEN_W = 8,
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LEN_W-1:0] len,
    input  logic [DIV_W-1:0] half_div,
    input  logic [TOTAL-1:0] load_bits,
    input  logic             miso,
    output logic             sclk,
    output logic             mosi,
    output logic             busy,
    output logic             done,
    output logic [TOTAL-1:0] rx_bits
);

    localparam logic [LEN_W-1:0] TOTAL_L = LEN_W'(TOTAL);

    typedef struct packed {
        eng_state_e       state;
        logic [TOTAL-1:0] sr;
        logic [LEN_W-1:0] remaining;
        logic             sclk;
        logic             rx_bit;
    } core_t;

    core_t c_d, c_q;
    logic  tick;
    logic  run;
    logic [LEN_W-1:0] shamt;

    assign run = (c_q.state == ENG_SHIFT);

    spi_sclk_div #(
        .DIV_W(DIV_W)
    ) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .half_div(half_div),
        .tick    (tick)
    );

    always_comb begin
        c_d   = c_q;
        shamt = TOTAL_L - len;
        case (c_q.state)
            ENG_IDLE: begin
                if (start) begin
                    c_d.state     = ENG_SHIFT;
                    c_d.sr        = load_bits << shamt;
                    c_d.remaining = len;
                    c_d.sclk      = 1'b0;
                end
            end
            ENG_SHIFT: begin
                if (tick) begin
                    if (!c_q.sclk) begin
                        // rising edge: sample the slave
                        c_d.sclk   = 1'b1;
                        c_d.rx_bit = miso;
                    end else begin
                        // falling edge: advance the shifter
                        c_d.sclk      = 1'b0;
                        c_d.sr        = {c_q.sr[TOTAL-2:0], c_q.rx_bit};
                        c_d.remaining = c_q.remaining - 1'b1;
                        if (c_q.remaining == LEN_W'(1)) begin
                            c_d.state = ENG_FINISH;
                        end
                    end
                end
            end
            ENG_FINISH: begin
                c_d.state = ENG_IDLE;
            end
            default: begin
                c_d.state = ENG_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign sclk    = c_q.sclk;
    assign mosi    = (c_q.state == ENG_SHIFT) ? c_q.sr[TOTAL-1] : 1'b0;
    assign busy    = (c_q.state != ENG_IDLE);
    assign done    = (c_q.state == ENG_FINISH);
    assign rx_bits = c_q.sr;

endmodule

// File: rtl/spi_wide_master.sv
module spi_wide_master
    import spi_wide_pkg::*;
#(
    parameter int NUM_WORDS = 4,
    parameter int WORD_W    = 32,
    parameter int NUM_SS    = 4,
    parameter int DIV_W     = 8
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             reg_wr,
    input  logic [$clog2(NUM_WORDS+2)-1:0]   reg_addr,
    input  logic [WORD_W-1:0]                reg_wdata,
    output logic [WORD_W-1:0]                reg_rdata,
    output logic                             sclk,
    output logic                             mosi,
    input  logic                             miso,
    output logic [NUM_SS-1:0]                ss_n
);

    localparam int TOTAL  = NUM_WORDS * WORD_W;
    localparam int ADDR_W = $clog2(NUM_WORDS + 2);
    localparam int WIDX_W = $clog2(NUM_WORDS);
    localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(NUM_WORDS);
    localparam logic [ADDR_W-1:0] SS_ADDR   = ADDR_W'(NUM_WORDS + 1);
    localparam logic [LEN_FIELD_W-1:0] TOTAL_LEN = LEN_FIELD_W'(TOTAL);

    typedef struct packed {
        logic [NUM_WORDS-1:0][WORD_W-1:0] words;
        logic [LEN_FIELD_W-1:0]           len;
        logic                             auto_ss;
        logic [DIV_W-1:0]                 half_div;
        logic [NUM_SS-1:0]                sel;
        logic [NUM_SS-1:0]                ss_n;
    } regs_t;

    regs_t r_d, r_q;

    logic                   eng_start;
    logic [LEN_FIELD_W-1:0] wr_len;
    logic [LEN_FIELD_W-1:0] eng_len;
    logic                   eng_busy;
    logic                   eng_done;
    logic [TOTAL-1:0]       eng_rx;
    logic                   busy_next;

    // Observation points for the bound checker
    logic                   chk_auto;
    logic [NUM_SS-1:0]      chk_sel;
    logic [LEN_FIELD_W-1:0] chk_len;

    spi_shift_core #(
        .TOTAL(TOTAL),
        .LEN_W(LEN_FIELD_W),
        .DIV_W(DIV_W)
    ) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (eng_start),
        .len      (eng_len),
        .half_div (r_q.half_div),
        .load_bits(r_q.words),
        .miso     (miso),
        .sclk     (sclk),
        .mosi     (mosi),
        .busy     (eng_busy),
        .done     (eng_done),
        .rx_bits  (eng_rx)
    );

    always_comb begin
        r_d       = r_q;
        eng_start = 1'b0;
        wr_len    = reg_wdata[CTRL_LEN_LSB +: LEN_FIELD_W];
        eng_len   = (wr_len > TOTAL_LEN) ? TOTAL_LEN : wr_len;
        if (reg_wr) begin
            if (reg_addr == SS_ADDR) begin
                r_d.sel = reg_wdata[NUM_SS-1:0];
            end else if (!eng_busy) begin
                if (reg_addr == CTRL_ADDR) begin
                    r_d.len      = wr_len;
                    r_d.auto_ss  = reg_wdata[CTRL_AUTO_BIT];
                    r_d.half_div = reg_wdata[CTRL_DIV_LSB +: DIV_W];
                    eng_start    = reg_wdata[CTRL_GO_BIT] && (wr_len != '0);
                end else if (reg_addr < CTRL_ADDR) begin
                    r_d.words[reg_addr[WIDX_W-1:0]] = reg_wdata;
                end
            end
        end
        if (eng_done) begin
            r_d.words = eng_rx;
        end
        busy_next = eng_start || (eng_busy && !eng_done);
        r_d.ss_n  = ~(r_d.sel & (r_d.auto_ss ? {NUM_SS{busy_next}} : {NUM_SS{1'b1}}));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.ss_n <= '1;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr < CTRL_ADDR) begin
            reg_rdata = r_q.words[reg_addr[WIDX_W-1:0]];
        end else if (reg_addr == CTRL_ADDR) begin
            reg_rdata[CTRL_LEN_LSB +: LEN_FIELD_W] = r_q.len;
            reg_rdata[CTRL_GO_BIT]                 = eng_busy;
            reg_rdata[CTRL_AUTO_BIT]               = r_q.auto_ss;
            reg_rdata[CTRL_DIV_LSB +: DIV_W]       = r_q.half_div;
        end else if (reg_addr == SS_ADDR) begin
            reg_rdata[NUM_SS-1:0] = r_q.sel;
        end
    end

    assign ss_n     = r_q.ss_n;
    assign chk_auto = r_q.auto_ss;
    assign chk_sel  = r_q.sel;
    assign chk_len  = r_q.len;

endmodule

// File: rtl/spi_wide_master_chk.sv
module spi_wide_master_chk #(
    parameter int NUM_SS = 4,
    parameter int ADDR_W = 3,
    parameter int LEN_W  = 8,
    parameter int CTRL_A = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sclk,
    input logic              busy,
    input logic              auto_ss,
    input logic [NUM_SS-1:0] sel,
    input logic [NUM_SS-1:0] ss_n,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [LEN_W-1:0]  len
);

    p_sclk_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sclk);

    p_auto_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_ss && !busy) |-> (&ss_n));

    p_auto_active_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_ss && busy) |-> (ss_n == ~sel));

    p_manual_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !auto_ss |-> (ss_n == ~sel));

    p_ctrl_locked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && reg_wr && (reg_addr == ADDR_W'(CTRL_A))) |=> $stable(len));

    p_busy_after_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && sclk) |=> busy);

endmodule

bind spi_wide_master spi_wide_master_chk #(
    .NUM_SS(NUM_SS),
    .ADDR_W(ADDR_W),
    .LEN_W (LEN_FIELD_W),
    .CTRL_A(NUM_WORDS)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .sclk    (sclk),
    .busy    (eng_busy),
    .auto_ss (chk_auto),
    .sel     (chk_sel),
    .ss_n    (ss_n),
    .reg_wr  (reg_wr),
    .reg_addr(reg_addr),
    .len     (chk_len)
);

// File: tb/test_spi_wide_master.sv
module test_spi_wide_master;

    localparam int CLK_PERIOD = 10;
    localparam int TOTAL      = 128;
    localparam logic [2:0] A_CTRL = 3'd4;
    localparam logic [2:0] A_SS   = 3'd5;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_wr;
    logic [2:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        sclk;
    logic        mosi;
    logic        miso;
    logic [3:0]  ss_n;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_wide_master i_spi_wide_master (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_wr   (reg_wr),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .sclk     (sclk),
        .mosi     (mosi),
        .miso     (miso),
        .ss_n     (ss_n)
    );

    // ---------------- counters, owned per process ----------------
    int n_checks = 0, n_fail = 0;       // driver
    int m_checks = 0, m_fail = 0;       // timing monitor
    int s_checks = 0, s_fail = 0;       // scoreboard monitor
    int wd_fail  = 0;
    bit reported = 1'b0;

    // ---------------- slave model on select 0 ----------------
    logic [127:0] slv_pattern = '0;     // driver owned
    int           slv_base    = 0;      // driver owned
    int           rise_total  = 0;      // slave owned
    logic [127:0] cap         = '0;     // slave owned

    always @(posedge sclk) begin
        if (!ss_n[0]) begin
            cap        <= {cap[126:0], mosi};
            rise_total <= rise_total + 1;
        end
    end

    always_comb begin
        int idx;
        idx  = rise_total - slv_base;
        miso = (idx >= 0 && idx < TOTAL) ? slv_pattern[127 - idx] : 1'b0;
    end

    // ---------------- timing monitor (R9, R10) ----------------
    int   cyc = 0;
    int   go_ref = 0, go_gen = 0, cur_div = 0;     // driver owned
    int   seen_gen = 0, last_toggle = 0, last_fall = 0;
    logic sclk_prev = 1'b0, mosi_prev = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (rst_n === 1'b1) begin
            if (mosi !== mosi_prev) begin
                m_checks++;
                if (sclk !== 1'b0) begin
                    m_fail++;
                    $display("FAIL R9: mosi changed with sclk=%b (expected 0)", sclk);
                end
            end
            if (sclk !== sclk_prev) begin
                m_checks++;
                if (go_gen != seen_gen) begin
                    seen_gen = go_gen;
                    if (cyc - go_ref != cur_div + 1) begin
                        m_fail++;
                        $display("FAIL R10: first edge after %0d clocks, expected %0d", cyc - go_ref, cur_div + 1);
                    end
                end else if (cyc - last_toggle != cur_div + 1) begin
                    m_fail++;
                    $display("FAIL R10: half period %0d clocks, expected %0d", cyc - last_toggle, cur_div + 1);
                end
                last_toggle = cyc;
                if (sclk === 1'b0) last_fall = cyc;
            end
        end
        sclk_prev = sclk;
        mosi_prev = mosi;
    end

    // ---------------- scoreboard ----------------
    typedef struct {
        logic [127:0] bits;
        int           n;
        string        tag;
    } sb_item_t;

    sb_item_t sb_q[$];
    int xfer_count = 0;   // driver owned
    int sb_seen    = 0;

    function automatic logic [127:0] lowmask(int n);
        if (n >= TOTAL) return '1;
        return (128'd1 << n) - 128'd1;
    endfunction

    always @(negedge clk) begin
        if (xfer_count != sb_seen && sb_q.size() > 0) begin
            sb_item_t it;
            sb_seen++;
            it = sb_q.pop_front();
            s_checks++;
            if ((cap & lowmask(it.n)) !== it.bits) begin
                s_fail++;
                $display("FAIL %s: mosi stream %h expected %h", it.tag, cap & lowmask(it.n), it.bits);
            end
        end
    end

    // ---------------- driver helpers ----------------
    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = A_CTRL;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
        reg_addr = A_CTRL;
    endtask

    function automatic logic [31:0] ctrl(int len, int div, bit auto_m, bit go);
        return (32'(div) << 16) | (32'(auto_m) << 9) | (32'(go) << 8) | 32'(len & 8'hFF);
    endfunction

    task automatic report();
        if (!reported) begin
            reported = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures",
                     n_checks + m_checks + s_checks + wd_fail, n_fail + m_fail + s_fail + wd_fail);
            $finish;
        end
    endtask

    // One burst: configure, load words, start, poll busy, verify.
    task automatic run_xfer(input int len, input int div, input bit auto_m,
                            input logic [127:0] tx, input logic [127:0] resp,
                            input bit poke, input string tag);
        int          nb;
        int          k;
        int          base;
        logic [31:0] d;
        logic [127:0] got;
        nb = (len > TOTAL) ? TOTAL : len;
        wr(A_CTRL, ctrl(len, div, auto_m, 1'b0));
        for (int i = 0; i < 4; i++) wr(3'(i), tx[32*i +: 32]);
        base        = rise_total;
        slv_base    = base;
        slv_pattern = (resp & lowmask(nb)) << (TOTAL - nb);
        sb_q.push_back('{bits: tx & lowmask(nb), n: nb, tag: tag});
        @(negedge clk);
        cur_div = div; go_ref = cyc + 1; go_gen++;
        reg_wr = 1'b1; reg_addr = A_CTRL; reg_wdata = ctrl(len, div, auto_m, 1'b1);
        @(negedge clk);
        reg_wr = 1'b0;
        check("R5 busy set after start", 128'(reg_rdata[8]), 128'd1);
        k = 0;
        while (reg_rdata[8] === 1'b1) begin
            @(negedge clk);
            k++;
            if (poke && k == 6) begin
                check(auto_m ? "R7 select low during burst" : "R8 select held during burst",
                      128'(ss_n), 128'(4'b1110));
                reg_wr = 1'b1; reg_wdata = ctrl(8, 0, auto_m, 1'b1);
            end else if (poke && k == 7) begin
                reg_wr = 1'b0;
            end
        end
        check("R5 busy clears one clock after last edge", 128'(cyc - last_fall), 128'd1);
        check("R4 sclk cycle count", 128'(rise_total - base), 128'(nb));
        xfer_count++;
        rd(A_CTRL, d);
        check("R6 length readback", 128'(d[7:0]), 128'(len & 8'hFF));
        got = '0;
        for (int i = 0; i < 4; i++) begin
            rd(3'(i), d);
            got[32*i +: 32] = d;
        end
        check("R3 received bits right-justified", got, resp & lowmask(nb));
    endtask

    // ---------------- stimulus ----------------
    initial begin
        logic [31:0] d;
        int          r0;
        rst_n = 1'b0; reg_wr = 1'b0; reg_addr = A_CTRL; reg_wdata = '0;
        repeat (4) @(negedge clk);
        // R1 reset state
        check("R1 ss_n after reset", 128'(ss_n), 128'(4'hF));
        check("R1 sclk after reset", 128'(sclk), 128'd0);
        rd(A_CTRL, d);
        check("R1 control word after reset", 128'(d), 128'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // Automatic select, slave 0
        wr(A_CTRL, ctrl(16, 1, 1'b1, 1'b0));
        wr(A_SS, 32'h1);
        check("R7 idle select high in auto mode", 128'(ss_n), 128'(4'hF));

        // R2 / R3 / R6: full 128-bit burst, start poked mid-burst
        run_xfer(128, 1, 1'b1,
                 {32'hA1A2A3A4, 32'hB5B6B7B8, 32'hC9CACBCC, 32'hD0D1D2D3},
                 {32'h5A5A0F0F, 32'h13579BDF, 32'h2468ACE0, 32'hFEDCBA98},
                 1'b1, "R2 128-bit word order");
        check("R7 select released after burst", 128'(ss_n), 128'(4'hF));

        // R3: 16-bit status read, upper words hold junk that must not be sent
        run_xfer(16, 3, 1'b1,
                 {32'hDEADBEEF, 32'hDEADBEEF, 32'hDEADBEEF, 32'hDEAD0500},
                 128'h00A5, 1'b0, "R2 16-bit low bits only");
        rd(3'd0, d);
        check("R3 status byte in word 0", 128'(d[7:0]), 128'hA5);

        // R8: manual select held across two bursts
        wr(A_CTRL, ctrl(32, 1, 1'b0, 1'b0));
        check("R8 manual select follows register", 128'(ss_n), 128'(4'b1110));
        run_xfer(32, 1, 1'b0, 128'h0200_1234, 128'h0, 1'b1, "R2 manual burst one");
        check("R8 select held between bursts", 128'(ss_n), 128'(4'b1110));
        run_xfer(32, 1, 1'b0, 128'hCAFE_F00D, 128'h8765_4321, 1'b0, "R2 manual burst two");
        check("R8 select held after bursts", 128'(ss_n), 128'(4'b1110));
        wr(A_SS, 32'h0);
        check("R8 manual select released", 128'(ss_n), 128'(4'hF));
        wr(A_SS, 32'h1);

        // R4: zero length is ignored
        r0 = rise_total;
        wr(A_CTRL, ctrl(0, 1, 1'b1, 1'b1));
        rd(A_CTRL, d);
        check("R4 zero length leaves busy clear", 128'(d[8]), 128'd0);
        repeat (20) @(negedge clk);
        check("R4 zero length gives no sclk edge", 128'(rise_total - r0), 128'd0);
        check("R7 no select for ignored start", 128'(ss_n), 128'(4'hF));

        // R4 / R10: length above 128 runs 128 bits, fastest divider
        run_xfer(200, 0, 1'b1,
                 {32'h01234567, 32'h89ABCDEF, 32'h0F1E2D3C, 32'h4B5A6978},
                 {32'h11112222, 32'h33334444, 32'h55556666, 32'h77778888},
                 1'b0, "R4 clamped length");

        repeat (10) @(negedge clk);
        report();
    end

    // Watchdog
    initial begin
        #(CLK_PERIOD * 150000);
        wd_fail = 1;
        $display("FAIL watchdog: run did not finish (expected completion)");
        report();
    end

endmodule